// File: doc/BRIEF.md
# Keyed-service watchdog timer

This block is a system watchdog reached through a small word-addressed register port with byte strobes. Software makes one write to the control register to set a 16-bit reload count, choose whether expiry raises a reset request or an interrupt, and choose whether each count step is stretched by a binary prescaler. That same write either starts the watchdog for good or leaves it off for good. Both choices last until the next power-on reset.

Once the watchdog runs, the counter steps down from the reload count. Software keeps the system alive by writing a fixed pair of 16-bit keys, in order, to the service register. A correct pair reloads the counter and restarts the prescaler. If the counter runs out, the block signals expiry in the selected way. It then reloads itself and keeps counting.

The port is a single-cycle request. A write takes effect at the clock edge where it is presented. Read data is registered and can be sampled one cycle after the read request.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, the control word reads 0xFFFF0003: reload count 0xFFFF, enable 0, select 1, prescale 1. The count word reads 0x0000FFFF, and both the interrupt and the reset request are low.
- R2: The control word is at offset 0x04. Its fields are: reload count in bits 31:16, enable in bit 2, select in bit 1, prescale in bit 0. Only the first write after reset that has any byte strobe set is accepted. In that write, strobes 3 and 2 update the upper and lower bytes of the count, strobe 0 updates the three flag bits, and fields whose strobes are clear keep their reset values. Every later control write is ignored.
- R3: The accepted control write loads the counter with the new reload count. If that write leaves enable at 0, the counter never moves again and neither expiry output is ever asserted, including after later control writes that set enable.
- R4: With prescale 0, the counter drops by one on every clock after the enabling write. With reload count N, expiry occurs on the Nth clock edge after each load.
- R5: With prescale 1, the counter drops by one every 2^PRE_LOG2 clocks. The first expiry therefore comes N·2^PRE_LOG2 edges after the load.
- R6: A valid service is 0x556C written to the service register, followed by 0xAA39 as the next service-register write. The service register is the upper halfword of word 0x0C: data bits 31:16, with strobes 3 and 2 both set. A valid service reloads the counter from the reload count and restarts the prescaler.
- R7: The key sequence has three rules. A service write of any value other than 0xAA39 after 0x556C returns the sequence to idle without a reload. A lone 0xAA39 does nothing. Writing 0x556C again keeps the sequence armed.
- R8: With select 1, each expiry drives the reset request high for exactly one cycle and leaves the interrupt low. The counter reloads and keeps counting.
- R9: With select 0, expiry sets the interrupt. The interrupt stays high until a valid service clears it on the edge of the second key.
- R10: The count word at offset 0x08 returns the counter value in bits 15:0, and writes to it are ignored. Read data appears one cycle after the read request.
- R11: Offsets 0x00 and 0x0C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address inside the 0x100-byte window, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes, bit n covers data bits 8n+7:8n |
| bus_rdata | output | 32 | Registered read data |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry |
| wdog_irq | output | 1 | Held interrupt on expiry |

## Verification
The bench runs each scenario from a fresh reset, because the control register takes a single write. The bench predicts the counter value at every read, both with and without the prescaler. A design that counted one edge off, or that failed to restart the prescaler on a service, would return the wrong value on nearly every read. The bench also breaks the key sequence in several ways, including a wrong second key, a lone second key and a repeated first key, to catch a sequencer that reloads too eagerly or loses its armed state. It further checks that a second control write cannot enable or change a watchdog that is already configured, that a partial-strobe first write keeps the unstrobed fields, and that the interrupt stays latched until the exact service edge.

// File: rtl/wdog_keyed_pkg.sv
package wdog_keyed_pkg;
    localparam int WIN_AW = 8;
    localparam int TC_W   = 16;

    localparam logic [WIN_AW-1:0] OFF_RSVD  = 8'h00;
    localparam logic [WIN_AW-1:0] OFF_CTRL  = 8'h04;
    localparam logic [WIN_AW-1:0] OFF_COUNT = 8'h08;
    localparam logic [WIN_AW-1:0] OFF_SVC   = 8'h0C;

    localparam int BIT_EN  = 2;
    localparam int BIT_SEL = 1;
    localparam int BIT_PRE = 0;

    localparam logic [15:0] KEY_ARM  = 16'h556C;
    localparam logic [15:0] KEY_FIRE = 16'hAA39;

    typedef struct packed {
        logic [TC_W-1:0] tc;
        logic            en;
        logic            sel;
        logic            pre;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{tc: 16'hFFFF, en: 1'b0, sel: 1'b1, pre: 1'b1};

    typedef enum logic {SEQ_IDLE, SEQ_ARMED} seq_e;

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[31:16]   = c.tc;
        w[BIT_EN]  = c.en;
        w[BIT_SEL] = c.sel;
        w[BIT_PRE] = c.pre;
        return w;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_keyed_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic [TC_W-1:0]   cnt_val,
    output ctrl_t             ctrl,
    output logic [TC_W-1:0]   ctrl_next_tc,
    output logic              ctrl_wr,
    output logic              locked,
    output logic              svc_wr,
    output logic [15:0]       svc_data,
    output logic [31:0]       rdata
);
    localparam int WORD_AW = WIN_AW - 2;

    typedef struct packed {
        ctrl_t       ctrl;
        logic        locked;
        logic [31:0] rdata;
    } regs_st_t;

    regs_st_t s_d, s_q;
    ctrl_t    merged;
    logic [WORD_AW-1:0] waddr;
    logic hit_ctrl, hit_svc, is_rd;
    logic unused_bits;

    assign waddr       = bus_addr[WIN_AW-1:2];
    assign unused_bits = ^{bus_wdata[15:3], bus_be[1], bus_addr[1:0]};

    always_comb begin
        s_d      = s_q;
        merged   = s_q.ctrl;
        ctrl_wr  = 1'b0;
        hit_ctrl = bus_req && bus_wr && (waddr == OFF_CTRL[WIN_AW-1:2]);
        hit_svc  = bus_req && bus_wr && (waddr == OFF_SVC[WIN_AW-1:2]);
        is_rd    = bus_req && !bus_wr;

        if (hit_ctrl && !s_q.locked && (|bus_be)) begin
            if (bus_be[3]) merged.tc[15:8] = bus_wdata[31:24];
            if (bus_be[2]) merged.tc[7:0]  = bus_wdata[23:16];
            if (bus_be[0]) begin
                merged.en  = bus_wdata[BIT_EN];
                merged.sel = bus_wdata[BIT_SEL];
                merged.pre = bus_wdata[BIT_PRE];
            end
            ctrl_wr    = 1'b1;
            s_d.ctrl   = merged;
            s_d.locked = 1'b1;
        end

        svc_wr   = hit_svc && (&bus_be[3:2]);
        svc_data = bus_wdata[31:16];

        if (is_rd) begin
            if (waddr == OFF_CTRL[WIN_AW-1:2])
                s_d.rdata = ctrl_word(s_q.ctrl);
            else if (waddr == OFF_COUNT[WIN_AW-1:2])
                s_d.rdata = {{(32-TC_W){1'b0}}, cnt_val};
            else
                s_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ctrl   <= CTRL_RST;
            s_q.locked <= 1'b0;
            s_q.rdata  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctrl         = s_q.ctrl;
    assign ctrl_next_tc = merged.tc;
    assign locked       = s_q.locked;
    assign rdata        = s_q.rdata;
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq
    import wdog_keyed_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_wr,
    input  logic [15:0] svc_data,
    output logic        svc_ok
);
    seq_e st_d, st_q;

    always_comb begin
        st_d   = st_q;
        svc_ok = 1'b0;
        if (svc_wr) begin
            if (st_q == SEQ_ARMED && svc_data == KEY_FIRE) begin
                svc_ok = 1'b1;
                st_d   = SEQ_IDLE;
            end else if (svc_data == KEY_ARM) begin
                st_d = SEQ_ARMED;
            end else begin
                st_d = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_keyed_pkg::*;
#(
    parameter int PRE_LOG2 = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TC_W-1:0] load_val,
    input  logic            run,
    input  logic            pre_en,
    output logic [TC_W-1:0] cnt,
    output logic            expire
);
    localparam int PW = (PRE_LOG2 < 1) ? 1 : PRE_LOG2;

    typedef struct packed {
        logic [TC_W-1:0] cnt;
        logic [PW-1:0]   pre;
    } cd_st_t;

    cd_st_t s_d, s_q;
    logic   tick;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        tick   = run && (!pre_en || (&s_q.pre));
        if (load) begin
            s_d.cnt = load_val;
            s_d.pre = '0;
        end else if (run) begin
            s_d.pre = s_q.pre + 1'b1;
            if (tick) begin
                if (s_q.cnt <= TC_W'(1)) begin
                    expire  = 1'b1;
                    s_d.cnt = load_val;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= CTRL_RST.tc;
            s_q.pre <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_keyed_pkg::*;
#(
    parameter int PRE_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              wdog_rst_req,
    output logic              wdog_irq
);
    typedef struct packed {
        logic rst_req;
        logic irq;
    } out_st_t;

    ctrl_t           ctrl;
    logic [TC_W-1:0] ctrl_next_tc;
    logic            ctrl_wr, locked, svc_wr, svc_ok, expire;
    logic [15:0]     svc_data;
    logic [TC_W-1:0] cnt;
    logic [TC_W-1:0] reload_val;
    out_st_t         o_d, o_q;

    wdog_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_be       (bus_be),
        .cnt_val      (cnt),
        .ctrl         (ctrl),
        .ctrl_next_tc (ctrl_next_tc),
        .ctrl_wr      (ctrl_wr),
        .locked       (locked),
        .svc_wr       (svc_wr),
        .svc_data     (svc_data),
        .rdata        (bus_rdata)
    );

    wdog_svc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_wr   (svc_wr),
        .svc_data (svc_data),
        .svc_ok   (svc_ok)
    );

    assign reload_val = ctrl_wr ? ctrl_next_tc : ctrl.tc;

    wdog_countdown #(.PRE_LOG2(PRE_LOG2)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctrl_wr || svc_ok),
        .load_val (reload_val),
        .run      (ctrl.en),
        .pre_en   (ctrl.pre),
        .cnt      (cnt),
        .expire   (expire)
    );

    always_comb begin
        o_d         = o_q;
        o_d.rst_req = expire && ctrl.sel;
        if (svc_ok)
            o_d.irq = 1'b0;
        else if (expire && !ctrl.sel)
            o_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign wdog_rst_req = o_q.rst_req;
    assign wdog_irq     = o_q.irq;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdog_keyed_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            irq,
    input logic            rst_req,
    input logic            svc_ok,
    input logic            expire,
    input logic            locked,
    input ctrl_t           ctrl,
    input logic [TC_W-1:0] cnt
);
    p_ctrl_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(ctrl));

    p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (!irq && !rst_req));

    p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ctrl.en && !svc_ok && !expire) |=>
            ((cnt <= $past(cnt)) && (32'(cnt) + 32'd1 >= 32'($past(cnt)))));

    p_svc_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> (cnt == $past(ctrl.tc)));

    p_rst_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && (ctrl.tc > 16'd1 || ctrl.pre)) |=> !rst_req);

    p_rst_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (ctrl.sel && !irq));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !svc_ok) |=> irq);

    p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !ctrl.sel);
endmodule

bind wdog_keyed wdog_keyed_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (wdog_irq),
    .rst_req (wdog_rst_req),
    .svc_ok  (svc_ok),
    .expire  (expire),
    .locked  (locked),
    .ctrl    (ctrl),
    .cnt     (cnt)
);

// File: tb/test_wdog_keyed.sv
`timescale 1ns/1ps
module test_wdog_keyed;
    localparam int PL = 3;
    localparam int M  = 1 << PL;
    localparam logic [7:0] A_RSVD = 8'h00, A_CTRL = 8'h04, A_CNT = 8'h08, A_SVC = 8'h0C;
    localparam logic [31:0] K1 = 32'h556C_0000, K2 = 32'hAA39_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_rdata;
    logic wdog_rst_req, wdog_irq;

    int cyc = 0;
    int rst_hi = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (wdog_rst_req) rst_hi <= rst_hi + 1;

    wdog_keyed #(.PRE_LOG2(PL)) i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .wdog_rst_req(wdog_rst_req), .wdog_irq(wdog_irq)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic acc(bit wr, logic [7:0] a, logic [31:0] d, logic [3:0] be, output int e);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        e = cyc;
        bus_req = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [3:0] be, output int e);
        acc(1'b1, a, d, be, e);
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d, output int e);
        acc(1'b0, a, '0, '0, e);
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_cnt(int n, int r, int b, bit pre);
        int t;
        t = r - 1 - b;
        if (pre) t = t / M;
        return 32'(n - (t % n));
    endfunction

    task automatic snap(output int v);
        #1 v = rst_hi;
    endtask

    initial begin : wdog_timer
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        int e, b, s, r0, r1, t;

        // S1: reset values, reserved words
        do_reset();
        check(!wdog_irq && !wdog_rst_req, "R1", {30'd0, wdog_irq, wdog_rst_req}, 0);
        rd(A_CTRL, d, e); check(d == 32'hFFFF0003, "R1", d, 32'hFFFF0003);
        rd(A_CNT, d, e);  check(d == 32'h0000FFFF, "R1", d, 32'h0000FFFF);
        rd(A_RSVD, d, e); check(d == 0, "R11", d, 0);
        rd(A_SVC, d, e);  check(d == 0, "R11", d, 0);

        // S7: partial strobe first write keeps count field, later write ignored
        do_reset();
        wr(A_CTRL, 32'h12340006, 4'b0001, e);
        wr(A_CTRL, 32'h00050002, 4'b1111, e);
        rd(A_CTRL, d, e); check(d == 32'hFFFF0006, "R2", d, 32'hFFFF0006);

        // S2: no prescale, reset mode, count sweep
        do_reset();
        wr(A_CTRL, 32'h00050006, 4'hF, b);
        snap(r0);
        wr(A_CTRL, 32'h00090001, 4'hF, e);
        rd(A_CTRL, d, e); check(d == 32'h00050006, "R2", d, 32'h00050006);
        for (int i = 0; i < 12; i++) begin
            rd(A_CNT, d, e);
            check(d == exp_cnt(5, e, b, 1'b0), "R4", d, exp_cnt(5, e, b, 1'b0));
        end
        wr(A_CNT, 32'h00001234, 4'hF, e);
        rd(A_CNT, d, e); check(d == exp_cnt(5, e, b, 1'b0), "R10", d, exp_cnt(5, e, b, 1'b0));
        snap(r1); t = cyc;
        check((r1 - r0) == (t - b) / 5, "R8", r1 - r0, (t - b) / 5);
        check(!wdog_irq, "R8", {31'd0, wdog_irq}, 0);

        // S3: left disabled, cannot be enabled later
        do_reset();
        snap(r0);
        wr(A_CTRL, 32'h00030002, 4'hF, b);
        wr(A_CTRL, 32'h00030006, 4'hF, e);
        repeat (20) @(negedge clk);
        rd(A_CNT, d, e);  check(d == 32'd3, "R3", d, 3);
        rd(A_CTRL, d, e); check(d == 32'h00030002, "R3", d, 32'h00030002);
        snap(r1);
        check(r1 == r0 && !wdog_irq, "R3", r1 - r0, 0);

        // S4: prescaled countdown
        do_reset();
        wr(A_CTRL, 32'h00030007, 4'hF, b);
        snap(r0);
        for (int i = 0; i < 30; i++) begin
            rd(A_CNT, d, e);
            check(d == exp_cnt(3, e, b, 1'b1), "R5", d, exp_cnt(3, e, b, 1'b1));
        end
        snap(r1); t = cyc;
        check((r1 - r0) == (t - b) / (3 * M), "R5", r1 - r0, (t - b) / (3 * M));

        // S5: interrupt mode, held until service
        do_reset();
        snap(r0);
        wr(A_CTRL, 32'h00040004, 4'hF, b);
        repeat (10) @(negedge clk);
        check(wdog_irq, "R9", {31'd0, wdog_irq}, 1);
        repeat (7) @(negedge clk);
        snap(r1);
        check(wdog_irq && r1 == r0, "R9", {31'd0, wdog_irq}, 1);
        wr(A_SVC, K1, 4'b1100, e);
        check(wdog_irq, "R9", {31'd0, wdog_irq}, 1);
        wr(A_SVC, K2, 4'b1100, s);
        check(!wdog_irq, "R9", {31'd0, wdog_irq}, 0);
        rd(A_CNT, d, e); check(d == 32'd4, "R6", d, 4);
        @(negedge clk); @(negedge clk);
        check(!wdog_irq, "R9", {31'd0, wdog_irq}, 0);
        @(negedge clk);
        check(wdog_irq, "R9", {31'd0, wdog_irq}, 1);

        // S6: broken key sequences
        do_reset();
        wr(A_CTRL, 32'h00060006, 4'hF, b);
        @(negedge clk); @(negedge clk);
        wr(A_SVC, K1, 4'b1100, e);
        wr(A_SVC, 32'h11110000, 4'b1100, e);
        rd(A_CNT, d, e); check(d == exp_cnt(6, e, b, 1'b0), "R7", d, exp_cnt(6, e, b, 1'b0));
        wr(A_SVC, K2, 4'b1100, e);
        rd(A_CNT, d, e); check(d == exp_cnt(6, e, b, 1'b0), "R7", d, exp_cnt(6, e, b, 1'b0));
        wr(A_SVC, K1, 4'b1100, e);
        wr(A_SVC, K1, 4'b1100, e);
        wr(A_SVC, K2, 4'b1100, s);
        rd(A_CNT, d, e); check(d == exp_cnt(6, e, s, 1'b0), "R7", d, exp_cnt(6, e, s, 1'b0));
        rd(A_CNT, d, e); check(d == exp_cnt(6, e, s, 1'b0), "R6", d, exp_cnt(6, e, s, 1'b0));

        // S8: service restarts the prescaler
        do_reset();
        wr(A_CTRL, 32'h00030007, 4'hF, b);
        repeat (5) @(negedge clk);
        wr(A_SVC, K1, 4'b1100, e);
        wr(A_SVC, K2, 4'b1100, s);
        for (int i = 0; i < 12; i++) begin
            rd(A_CNT, d, e);
            check(d == exp_cnt(3, e, s, 1'b1), "R6", d, exp_cnt(3, e, s, 1'b1));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule